// File: doc/BRIEF.md
# Console Keyboard/Display Register Slave

This block is a bus slave for a simple text console. It exposes a keyboard input port and a display output port as four 32-bit word registers in a small address window at the top of the address map. A keyboard data word and a display data word each carry one character in their low byte. Each port also has a control word that holds a ready flag and an interrupt-enable flag. Software either polls the ready flag or enables the interrupt. It then reads the pending key or writes the next character.

The block compares the upper bits of every request address with the window base. It answers only requests that fall inside the window. A response comes one cycle after the request and carries the read data. Touching a data register changes the ready flag as a side effect. Reading keyboard data consumes the key. Writing display data hands the byte to the display stub, and the display port stays busy until the stub acknowledges it. Each port drives an interrupt line that is high while the port is ready and its enable is set.

Top module: `console_mmio_regs`

## Requirements
- R1: After reset, the keyboard control word reads 0, the display control word reads 1 (display ready), both interrupt lines are low and `disp_valid` is low.
- R2: A request whose address lies outside the 32-byte window starting at 0xFFFF0000 produces no response and changes no state. A request inside the window gets `bus_rsp` high exactly one cycle later, with read data on `bus_rdata` (zero for writes).
- R3: A `kbd_valid` pulse stores `kbd_byte` and sets the keyboard ready flag. A read of the keyboard data word (0xFFFF0004) returns the stored byte in bits 7:0 with zeros above it, and clears the ready flag.
- R4: If a key arrives in the same cycle as a read of the keyboard data word, the read returns the old byte, the new byte is kept, and the ready flag stays set.
- R5: A write to the display data word (0xFFFF000C) while the display is ready puts bits 7:0 on `disp_byte`, raises `disp_valid` and clears the display ready flag. In the cycle after `disp_ack` is sampled high, `disp_valid` is low and the ready flag is set again.
- R6: Control words (keyboard at 0xFFFF0000, display at 0xFFFF0008) read with bit 0 = ready, bit 1 = interrupt enable, and all other bits zero. A write changes only bit 1; bit 0 and the upper bits of the write are ignored.
- R7: `kbd_irq` and `disp_irq` are each high exactly when the port's ready flag and enable flag are both set.
- R8: In-window offsets that are not word-aligned offsets 0x0, 0x4, 0x8 or 0xC (for example 0x10, 0x1C, 0x2) read as zero and have no effect on writes. Writes to the keyboard data word are also ignored.
- R9: A display data write made while the display is busy is dropped, and `disp_byte` holds its value until the acknowledge. A read of the display data word returns the last byte that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rsp | output | 1 | Response strobe, one cycle after an in-window request |
| bus_rdata | output | 32 | Read data, valid with bus_rsp |
| kbd_valid | input | 1 | Keyboard stub presents a new key byte |
| kbd_byte | input | 8 | Key byte |
| disp_valid | output | 1 | Character pending for the display stub |
| disp_byte | output | 8 | Pending character |
| disp_ack | input | 1 | Display stub accepts the pending character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
A wrong ready flag shows up on the interrupt line in the very next cycle whenever the enable is set. It also shows up in the low bit of the next control-word read. A decode fault that hits the wrong register appears in the next response word. It can also surface later, as a ready flag cleared or an enable set that no access should have touched. Those are caught by the control reads that follow each unmapped or out-of-window access. A display handshake that releases early or late shows as `disp_valid` or `disp_byte` disagreeing with the acknowledge history within one cycle.

// File: rtl/console_pkg.sv
package console_pkg;

    // Bit positions inside a control word
    localparam int unsigned RDY_BIT = 0;
    localparam int unsigned IE_BIT  = 1;

    // Register picked by the address decoder
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_KCTRL = 3'd1,
        SEL_KDATA = 3'd2,
        SEL_DCTRL = 3'd3,
        SEL_DDATA = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/console_addr_decode.sv
module console_addr_decode
    import console_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000,
    parameter int unsigned WIN_BYTES = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output reg_sel_e          sel
);
    localparam int unsigned OFF_W = $clog2(WIN_BYTES);
    localparam int unsigned IDX_W = OFF_W - 2;

    logic [OFF_W-1:0] offset;
    logic [IDX_W-1:0] word_idx;

    assign offset   = addr[OFF_W-1:0];
    assign word_idx = offset[OFF_W-1:2];
    assign in_win   = (addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);

    always_comb begin
        sel = SEL_NONE;
        if (in_win && offset[1:0] == 2'b00) begin
            if      (word_idx == IDX_W'(0)) sel = SEL_KCTRL;
            else if (word_idx == IDX_W'(1)) sel = SEL_KDATA;
            else if (word_idx == IDX_W'(2)) sel = SEL_DCTRL;
            else if (word_idx == IDX_W'(3)) sel = SEL_DDATA;
            else                            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/console_kbd_port.sv
module console_kbd_port #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    input  logic              data_rd,
    input  logic              ie_wr,
    input  logic              ie_wdata,
    output logic              rdy,
    output logic              ie,
    output logic [CHAR_W-1:0] held_byte
);
    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic [CHAR_W-1:0] chr;
    } kbd_state_t;

    kbd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ie_wr)   st_d.ie  = ie_wdata;
        if (data_rd) st_d.rdy = 1'b0;
        // a fresh key wins over the consuming read
        if (key_valid) begin
            st_d.rdy = 1'b1;
            st_d.chr = key_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy       = st_q.rdy;
    assign ie        = st_q.ie;
    assign held_byte = st_q.chr;
endmodule

// File: rtl/console_disp_port.sv
module console_disp_port #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wr_byte,
    input  logic              ack,
    input  logic              ie_wr,
    input  logic              ie_wdata,
    output logic              rdy,
    output logic              ie,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_byte
);
    typedef struct packed {
        logic              busy;
        logic              ie;
        logic [CHAR_W-1:0] chr;
    } disp_state_t;

    disp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ie_wr) st_d.ie = ie_wdata;
        if (st_q.busy) begin
            if (ack) st_d.busy = 1'b0;
        end else if (data_wr) begin
            st_d.busy = 1'b1;
            st_d.chr  = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy       = !st_q.busy;
    assign ie        = st_q.ie;
    assign out_valid = st_q.busy;
    assign out_byte  = st_q.chr;
endmodule

// File: rtl/console_mmio_regs.sv
module console_mmio_regs
    import console_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CHAR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000,
    parameter int unsigned WIN_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rsp,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kbd_valid,
    input  logic [CHAR_W-1:0] kbd_byte,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    input  logic              disp_ack,
    output logic              kbd_irq,
    output logic              disp_irq
);
    typedef struct packed {
        logic              rsp;
        logic [DATA_W-1:0] rdata;
    } rsp_state_t;

    logic     in_win;
    reg_sel_e sel;
    logic     acc;
    logic     kbd_data_rd, kbd_ie_wr, disp_data_wr, disp_ie_wr;
    logic     kbd_rdy, kbd_ie, disp_rdy, disp_ie;
    logic [CHAR_W-1:0] kbd_held;

    rsp_state_t rsp_d, rsp_q;

    console_addr_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)
    ) dec_i (
        .addr(bus_addr), .in_win(in_win), .sel(sel)
    );

    assign acc          = bus_req && in_win;
    assign kbd_data_rd  = acc && !bus_we && (sel == SEL_KDATA);
    assign kbd_ie_wr    = acc &&  bus_we && (sel == SEL_KCTRL);
    assign disp_data_wr = acc &&  bus_we && (sel == SEL_DDATA);
    assign disp_ie_wr   = acc &&  bus_we && (sel == SEL_DCTRL);

    console_kbd_port #(.CHAR_W(CHAR_W)) kbd_i (
        .clk(clk), .rst_n(rst_n),
        .key_valid(kbd_valid), .key_byte(kbd_byte),
        .data_rd(kbd_data_rd),
        .ie_wr(kbd_ie_wr), .ie_wdata(bus_wdata[IE_BIT]),
        .rdy(kbd_rdy), .ie(kbd_ie), .held_byte(kbd_held)
    );

    console_disp_port #(.CHAR_W(CHAR_W)) disp_i (
        .clk(clk), .rst_n(rst_n),
        .data_wr(disp_data_wr), .wr_byte(bus_wdata[CHAR_W-1:0]),
        .ack(disp_ack),
        .ie_wr(disp_ie_wr), .ie_wdata(bus_wdata[IE_BIT]),
        .rdy(disp_rdy), .ie(disp_ie),
        .out_valid(disp_valid), .out_byte(disp_byte)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.rsp   = acc;
        rsp_d.rdata = '0;
        if (acc && !bus_we) begin
            unique case (sel)
                SEL_KCTRL: begin
                    rsp_d.rdata[RDY_BIT] = kbd_rdy;
                    rsp_d.rdata[IE_BIT]  = kbd_ie;
                end
                SEL_KDATA: rsp_d.rdata[CHAR_W-1:0] = kbd_held;
                SEL_DCTRL: begin
                    rsp_d.rdata[RDY_BIT] = disp_rdy;
                    rsp_d.rdata[IE_BIT]  = disp_ie;
                end
                SEL_DDATA: rsp_d.rdata[CHAR_W-1:0] = disp_byte;
                default:   rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rsp   = rsp_q.rsp;
    assign bus_rdata = rsp_q.rdata;
    assign kbd_irq   = kbd_rdy && kbd_ie;
    assign disp_irq  = disp_rdy && disp_ie;
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_rsp,
    input logic       kbd_valid,
    input logic       kbd_rdy,
    input logic       disp_valid,
    input logic       disp_ack,
    input logic       disp_rdy,
    input logic [7:0] disp_byte
);
    // R2
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rsp |-> $past(bus_req));

    // R3
    key_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_valid |=> kbd_rdy);

    // R5
    ack_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ack) |=> (disp_rdy && !disp_valid));

    // R9
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ack) |=> (disp_valid && $stable(disp_byte)));
endmodule

bind console_mmio_regs console_mmio_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_rsp(bus_rsp),
    .kbd_valid(kbd_valid), .kbd_rdy(kbd_rdy),
    .disp_valid(disp_valid), .disp_ack(disp_ack), .disp_rdy(disp_rdy),
    .disp_byte(disp_byte)
);

// File: tb/console_mmio_regs_tb.sv
module console_mmio_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_rsp;
    logic [31:0] bus_rdata;
    logic        kbd_valid = 1'b0;
    logic [7:0]  kbd_byte = '0;
    logic        disp_valid;
    logic [7:0]  disp_byte;
    logic        disp_ack = 1'b0;
    logic        kbd_irq, disp_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    console_mmio_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rsp(bus_rsp), .bus_rdata(bus_rdata),
        .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
        .disp_valid(disp_valid), .disp_byte(disp_byte), .disp_ack(disp_ack),
        .kbd_irq(kbd_irq), .disp_irq(disp_irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares every response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rsp) begin
            if (sb_q.size() == 0) begin
                chk("R2 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    // driver: one access; in_win decides if a response is expected
    task automatic bus_op(bit we, logic [31:0] addr, logic [31:0] wd,
                          logic [31:0] exp, bit in_win, string tag);
        @(negedge clk);
        if (in_win) sb_q.push_back('{exp: (we ? 32'd0 : exp), tag: tag});
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [31:0] addr, logic [31:0] exp, string tag);
        bus_op(1'b0, addr, 32'd0, exp, 1'b1, tag);
    endtask

    task automatic wr(logic [31:0] addr, logic [31:0] wd, string tag);
        bus_op(1'b1, addr, wd, 32'd0, 1'b1, tag);
    endtask

    task automatic press(logic [7:0] b);
        @(negedge clk);
        kbd_valid = 1'b1; kbd_byte = b;
        @(negedge clk);
        kbd_valid = 1'b0;
    endtask

    task automatic ack_disp();
        @(negedge clk);
        disp_ack = 1'b1;
        @(negedge clk);
        disp_ack = 1'b0;
    endtask

    localparam logic [31:0] KC = 32'hFFFF_0000, KD = 32'hFFFF_0004;
    localparam logic [31:0] DC = 32'hFFFF_0008, DD = 32'hFFFF_000C;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 kbd_irq", {31'd0, kbd_irq}, 32'd0);
        chk("R1 disp_irq", {31'd0, disp_irq}, 32'd0);
        chk("R1 disp_valid", {31'd0, disp_valid}, 32'd0);
        rd(KC, 32'd0, "R1 kbd ctrl");
        rd(DC, 32'd1, "R1 disp ctrl");

        // R6 only the enable bit is writable
        wr(KC, 32'hFFFF_FFFF, "R6 write");
        rd(KC, 32'h2, "R6 kbd ctrl readback");
        chk("R7 kbd_irq without ready", {31'd0, kbd_irq}, 32'd0);

        // R3 key then consuming read
        press(8'h41);
        chk("R7 kbd_irq ready+ie", {31'd0, kbd_irq}, 32'd1);
        rd(KC, 32'h3, "R3 ready set");
        rd(KD, 32'h41, "R3 data byte");
        rd(KC, 32'h2, "R3 ready cleared");
        chk("R7 kbd_irq after read", {31'd0, kbd_irq}, 32'd0);

        // R4 key arriving with the consuming read
        press(8'h10);
        @(negedge clk);
        sb_q.push_back('{exp: 32'h10, tag: "R4 old byte"});
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = KD;
        kbd_valid = 1'b1; kbd_byte = 8'h22;
        @(negedge clk);
        bus_req = 1'b0; kbd_valid = 1'b0;
        rd(KC, 32'h3, "R4 ready kept");
        rd(KD, 32'h22, "R4 new byte");

        // R8 keyboard data is read-only
        wr(KD, 32'h99, "R8 kbd data write");
        rd(KD, 32'h22, "R8 kbd data unchanged");
        rd(KC, 32'h2, "R8 kbd ctrl unchanged");

        // R5 / R9 display path
        wr(DC, 32'h2, "R6 disp ie");
        rd(DC, 32'h3, "R6 disp ctrl");
        chk("R7 disp_irq", {31'd0, disp_irq}, 32'd1);
        wr(DD, 32'hABCD_EF5A, "R5 write char");
        chk("R5 disp_valid", {31'd0, disp_valid}, 32'd1);
        chk("R5 disp_byte", {24'd0, disp_byte}, 32'h5A);
        chk("R7 disp_irq busy", {31'd0, disp_irq}, 32'd0);
        rd(DC, 32'h2, "R5 not ready");
        wr(DD, 32'h77, "R9 write while busy");
        chk("R9 byte held", {24'd0, disp_byte}, 32'h5A);
        rd(DD, 32'h5A, "R9 data readback");
        ack_disp();
        chk("R5 valid dropped", {31'd0, disp_valid}, 32'd0);
        chk("R7 disp_irq after ack", {31'd0, disp_irq}, 32'd1);
        rd(DC, 32'h3, "R5 ready again");

        // R8 unmapped offsets
        rd(32'hFFFF_0010, 32'd0, "R8 off 0x10");
        rd(32'hFFFF_001C, 32'd0, "R8 off 0x1C");
        rd(32'hFFFF_0002, 32'd0, "R8 unaligned");
        wr(32'hFFFF_0014, 32'hFFFF_FFFF, "R8 unmapped write");
        rd(KC, 32'h2, "R8 kbd ctrl intact");
        rd(DC, 32'h3, "R8 disp ctrl intact");

        // R2 outside the window
        bus_op(1'b0, 32'hFFFF_0020, 32'd0, 32'd0, 1'b0, "R2");
        chk("R2 no rsp above window", {31'd0, bus_rsp}, 32'd0);
        bus_op(1'b1, 32'hFFFE_0008, 32'd0, 32'd0, 1'b0, "R2");
        chk("R2 no rsp below window", {31'd0, bus_rsp}, 32'd0);
        rd(DC, 32'h3, "R2 disp ctrl untouched");

        // R7 enable cleared masks the interrupt
        wr(KC, 32'h0, "R7 disable");
        press(8'h33);
        chk("R7 kbd_irq masked", {31'd0, kbd_irq}, 32'd0);
        rd(KC, 32'h1, "R7 ready without ie");

        repeat (3) @(negedge clk);
        chk("R2 all responses seen", sb_q.size(), 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule